// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is a byte-wide input port that a peripheral fills by pulling an active-low strobe. While the strobe is low the port's register keeps copying the data pins. When the strobe returns high, the register holds the captured byte and ignores any later change on the pins. A buffer-full flag rises on the strobe's falling edge and serves as the acknowledge back to the device. When interrupts are enabled, an interrupt request rises on the strobe's rising edge to tell the CPU that a byte is waiting.

The CPU reads the byte with a read strobe that is high while the read is in progress. The start of the read drops the interrupt request, and the end of the read empties the buffer. If a new strobe arrives while the buffer is still full, the new byte replaces the old one and a sticky overrun bit is set. A status read clears that bit. The status byte places the flags in one of two layouts, selected by a parameter for the first or the second port group.

The sequencing is a four-state machine:
- EMPTY: no byte is held.
- LOAD: the strobe is low and the register is copying the pins.
- FULL: a byte is held and the strobe is high.
- READ: a CPU read is in progress.

Transitions:
- strobe fall: EMPTY→LOAD, FULL→LOAD and READ→LOAD.
- strobe rise: LOAD→FULL.
- read start: FULL→READ.
- read end: READ→EMPTY.

Top module: `hsp_strobe_port`

## Requirements
- R1: After reset, buffer-full, interrupt request, interrupt enable and overrun are all 0, so the status byte reads 0x00.
- R2: On the first clock edge that sees the strobe low after it was high, buffer-full goes to 1. The data register copies the pins on every clock edge that sees the strobe low, so it keeps the pin value from the last low edge.
- R3: Once the strobe is high, pin changes have no effect on the held byte that the CPU read returns.
- R4: The interrupt request rises only on the edge where the strobe is seen returning high, and only if interrupts are enabled at that moment. It stays 0 while the strobe is low.
- R5: With interrupts disabled, a completed strobe sets buffer-full but leaves the interrupt request at 0. The interrupt request is never 1 while buffer-full is 0.
- R6: The edge that sees the CPU read rise clears the interrupt request, and buffer-full stays 1 during the read. The edge that sees the read low again moves an undisturbed read to EMPTY, so buffer-full goes to 0.
- R7: A strobe fall in FULL or READ overwrites the held byte and sets the overrun bit. The overrun bit stays 1 through data reads until a status read pulse clears it.
- R8: In the status byte, the first group (GROUP_B=0) has overrun on bit 7, buffer-full on bit 5, enable on bit 4 and request on bit 3. The second group has overrun on bit 3, enable on bit 2, buffer-full on bit 1 and request on bit 0. All other bits are 0.
- R9: Writing the enable to 0 clears a pending interrupt request on the same edge. Buffer-full is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pins_i | input | WIDTH | Peripheral data pins |
| stb_n_i | input | 1 | Active-low load strobe from the peripheral |
| rd_i | input | 1 | CPU data read, high for the whole read |
| ie_we_i | input | 1 | Write strobe for the interrupt enable |
| ie_d_i | input | 1 | New interrupt enable value |
| stat_rd_i | input | 1 | Status read pulse, clears overrun |
| rd_data_o | output | WIDTH | Held byte |
| ibf_o | output | 1 | Buffer-full / acknowledge to the peripheral |
| intr_o | output | 1 | Interrupt request to the CPU |
| status_o | output | 8 | Status byte in the group's layout |

## Verification
The hardest case to reach is an overrun: a second byte has to arrive while the first is still unread, and its bits must then be checked in the status byte across reads. The stimulus first completes a strobe with interrupts disabled. It then issues another full strobe before any read, and checks the overrun bit after a data read and again after a status read. A second instance built for the other group receives the same stimulus, so both status layouts are compared against the same flag values.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_LOAD,
        ST_FULL,
        ST_READ
    } buf_state_t;

    typedef struct packed {
        logic ovr;
        logic ibf;
        logic inte;
        logic intr;
    } flags_t;
endpackage

// File: rtl/hsp_edge.sv
module hsp_edge #(
    parameter logic IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= sig_i;
    end

    assign rise_o = sig_i & ~prev_q;
    assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/hsp_latch.sv
module hsp_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end
endmodule

// File: rtl/hsp_ctrl.sv
module hsp_ctrl
    import hsp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stb_fall_i,
    input  logic   stb_rise_i,
    input  logic   rd_rise_i,
    input  logic   rd_i,
    input  logic   ie_we_i,
    input  logic   ie_d_i,
    input  logic   stat_rd_i,
    output flags_t flags_o
);
    buf_state_t state_q, state_d;
    logic       inte_q, intr_q, ovr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (stb_fall_i) state_d = ST_LOAD;
            ST_LOAD:  if (stb_rise_i) state_d = ST_FULL;
            ST_FULL: begin
                if (stb_fall_i)     state_d = ST_LOAD;
                else if (rd_rise_i) state_d = ST_READ;
            end
            ST_READ: begin
                if (stb_fall_i) state_d = ST_LOAD;
                else if (!rd_i) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inte_q <= 1'b0;
            intr_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (ie_we_i) inte_q <= ie_d_i;

            if (ie_we_i && !ie_d_i)                               intr_q <= 1'b0;
            else if (rd_rise_i)                                   intr_q <= 1'b0;
            else if (state_q == ST_LOAD && stb_rise_i && inte_q)  intr_q <= 1'b1;

            if (stb_fall_i && (state_q == ST_FULL || state_q == ST_READ)) ovr_q <= 1'b1;
            else if (stat_rd_i)                                           ovr_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        flags_o.ibf  = (state_q != ST_EMPTY);
        flags_o.intr = intr_q;
        flags_o.inte = inte_q;
        flags_o.ovr  = ovr_q;
    end
endmodule

// File: rtl/hsp_status.sv
module hsp_status
    import hsp_pkg::*;
#(
    parameter bit GROUP_B = 1'b0,
    parameter int SW      = 8
) (
    input  flags_t        flags_i,
    output logic [SW-1:0] status_o
);
    localparam int OVR_BIT  = GROUP_B ? 3 : 7;
    localparam int IBF_BIT  = GROUP_B ? 1 : 5;
    localparam int INTE_BIT = GROUP_B ? 2 : 4;
    localparam int INTR_BIT = GROUP_B ? 0 : 3;

    always_comb begin
        status_o           = '0;
        status_o[OVR_BIT]  = flags_i.ovr;
        status_o[IBF_BIT]  = flags_i.ibf;
        status_o[INTE_BIT] = flags_i.inte;
        status_o[INTR_BIT] = flags_i.intr;
    end
endmodule

// File: rtl/hsp_strobe_port.sv
module hsp_strobe_port
    import hsp_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit GROUP_B = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    input  logic             stb_n_i,
    input  logic             rd_i,
    input  logic             ie_we_i,
    input  logic             ie_d_i,
    input  logic             stat_rd_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             ibf_o,
    output logic             intr_o,
    output logic [7:0]       status_o
);
    logic   stb_rise, stb_fall, rd_rise, rd_fall_unused;
    flags_t flags;

    hsp_edge #(.IDLE(1'b1)) u_stb_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(stb_n_i),
        .rise_o(stb_rise), .fall_o(stb_fall)
    );

    hsp_edge #(.IDLE(1'b0)) u_rd_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(rd_i),
        .rise_o(rd_rise), .fall_o(rd_fall_unused)
    );

    hsp_latch #(.WIDTH(WIDTH)) u_latch (
        .clk(clk), .rst_n(rst_n), .load_i(~stb_n_i),
        .d_i(pins_i), .q_o(rd_data_o)
    );

    hsp_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .stb_fall_i(stb_fall), .stb_rise_i(stb_rise),
        .rd_rise_i(rd_rise), .rd_i(rd_i),
        .ie_we_i(ie_we_i), .ie_d_i(ie_d_i), .stat_rd_i(stat_rd_i),
        .flags_o(flags)
    );

    hsp_status #(.GROUP_B(GROUP_B), .SW(8)) u_status (
        .flags_i(flags), .status_o(status_o)
    );

    assign ibf_o  = flags.ibf;
    assign intr_o = flags.intr;
endmodule

// File: rtl/hsp_strobe_port_chk.sv
module hsp_strobe_port_chk #(
    parameter bit GROUP_B = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       stb_n_i,
    input logic       rd_i,
    input logic       stat_rd_i,
    input logic       ibf_o,
    input logic       intr_o,
    input logic [7:0] status_o
);
    localparam int OVR_BIT  = GROUP_B ? 3 : 7;
    localparam int IBF_BIT  = GROUP_B ? 1 : 5;
    localparam int INTE_BIT = GROUP_B ? 2 : 4;
    localparam int INTR_BIT = GROUP_B ? 0 : 3;

    a_r2_fall_sets_ibf: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_n_i) |=> ibf_o);

    a_r4_intr_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr_o) |-> ($past(stb_n_i) && !$past(stb_n_i, 2)));

    a_r5_intr_needs_ibf: assert property (@(posedge clk) disable iff (!rst_n)
        intr_o |-> ibf_o);

    a_r6_read_clears_intr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_i) |=> !intr_o);

    a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[OVR_BIT] && !stat_rd_i) |=> status_o[OVR_BIT]);

    a_r8_status_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[IBF_BIT] == ibf_o) && (status_o[INTR_BIT] == intr_o));

    a_r9_no_intr_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[INTE_BIT] |-> !intr_o);
endmodule

bind hsp_strobe_port hsp_strobe_port_chk #(.GROUP_B(GROUP_B)) u_chk (
    .clk(clk), .rst_n(rst_n), .stb_n_i(stb_n_i), .rd_i(rd_i),
    .stat_rd_i(stat_rd_i), .ibf_o(ibf_o), .intr_o(intr_o), .status_o(status_o)
);

// File: tb/tb_hsp_strobe_port.sv
`timescale 1ns/1ps
module tb_hsp_strobe_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'h00;
    logic       stb_n = 1'b1;
    logic       rd = 1'b0;
    logic       ie_we = 1'b0;
    logic       ie_d = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rdata_a, rdata_b, stat_a, stat_b;
    logic       ibf_a, ibf_b, intr_a, intr_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit exp_full = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    hsp_strobe_port #(.WIDTH(8), .GROUP_B(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .stb_n_i(stb_n), .rd_i(rd),
        .ie_we_i(ie_we), .ie_d_i(ie_d), .stat_rd_i(stat_rd),
        .rd_data_o(rdata_a), .ibf_o(ibf_a), .intr_o(intr_a), .status_o(stat_a)
    );

    hsp_strobe_port #(.WIDTH(8), .GROUP_B(1'b1)) dut_b (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .stb_n_i(stb_n), .rd_i(rd),
        .ie_we_i(ie_we), .ie_d_i(ie_d), .stat_rd_i(stat_rd),
        .rd_data_o(rdata_b), .ibf_o(ibf_b), .intr_o(intr_b), .status_o(stat_b)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: completes a strobe, pushes the expected byte into the scoreboard
    task automatic strobe_byte(logic [7:0] first, logic [7:0] last, int low_cycles);
        pins = first;
        stb_n = 1'b0;
        cyc(1);
        chk("R2 ibf after fall", {7'd0, ibf_a}, 8'h01);
        chk("R4 no intr while low", {7'd0, intr_a}, 8'h00);
        pins = last;
        cyc(low_cycles);
        stb_n = 1'b1;
        cyc(1);
        pins = ~last;   // R3: pins move after capture
        if (exp_full) exp_q[exp_q.size()-1] = last;
        else          exp_q.push_back(last);
        exp_full = 1;
    endtask

    task automatic cpu_read(bit expect_ovr_after);
        rd = 1'b1;
        cyc(1);
        chk("R6 intr cleared at read start", {7'd0, intr_a}, 8'h00);
        chk("R6 ibf held during read", {7'd0, ibf_a}, 8'h01);
        cyc(1);
        rd = 1'b0;
        cyc(1);
        exp_full = 0;
        chk("R6 ibf cleared after read", {7'd0, ibf_a}, 8'h00);
        chk("R7 overrun after data read", {7'd0, stat_a[7]}, {7'd0, expect_ovr_after});
    endtask

    task automatic set_ie(bit v);
        ie_we = 1'b1;
        ie_d = v;
        cyc(1);
        ie_we = 1'b0;
    endtask

    // monitor: compares the read data against the scoreboard
    initial begin
        forever begin
            @(posedge rd);
            @(negedge clk);
            if (exp_q.size() == 0) begin
                chk("R3 unexpected read", rdata_a, 8'hxx);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk("R3 read data A", rdata_a, e);
                chk("R3 read data B", rdata_b, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 status A after reset", stat_a, 8'h00);
        chk("R1 status B after reset", stat_b, 8'h00);
        chk("R1 ibf/intr after reset", {6'd0, ibf_a, intr_a}, 8'h00);

        set_ie(1'b1);
        chk("R8 enable bit A", stat_a, 8'h10);
        chk("R8 enable bit B", stat_b, 8'h04);

        // R2 last low sample wins, R4 interrupt on rise
        strobe_byte(8'h11, 8'hA5, 2);
        chk("R4 intr after rise", {7'd0, intr_a}, 8'h01);
        cyc(2);
        chk("R8 status A full+ie+intr", stat_a, 8'h38);
        chk("R8 status B full+ie+intr", stat_b, 8'h07);
        chk("R3 held byte after pins move", rdata_a, 8'hA5);
        cpu_read(1'b0);

        // R5 interrupts disabled, then R7 overrun
        set_ie(1'b0);
        strobe_byte(8'h3C, 8'h3C, 1);
        chk("R5 no intr when disabled", {6'd0, ibf_a, intr_a}, 8'h02);
        strobe_byte(8'h00, 8'hC3, 3);
        chk("R7 overrun set A", stat_a, 8'hA0);
        chk("R7 overrun set B", stat_b, 8'h0A);
        cpu_read(1'b1);
        stat_rd = 1'b1;
        cyc(1);
        stat_rd = 1'b0;
        chk("R7 overrun cleared by status read", stat_a, 8'h00);

        // R9 disabling drops a pending request
        set_ie(1'b1);
        strobe_byte(8'h5A, 8'h96, 1);
        chk("R9 intr pending", {7'd0, intr_a}, 8'h01);
        set_ie(1'b0);
        chk("R9 intr dropped, ibf kept", stat_a, 8'h20);
        cpu_read(1'b0);
        cyc(2);
        chk("R3 scoreboard drained", 8'(exp_q.size()), 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule